// File: doc/BRIEF.md
# Octant-Symmetric Twiddle Rotator

This block rotates one complex sample by the FFT twiddle factor W^k = cos(2πk/N) − j·sin(2πk/N) for a transform of N = 2^LOG2N points, with LOG2N from 4 to 11. It is one stage of a pipelined FFT datapath. Each cycle it can take a new sample, its twiddle index and a valid flag. After a fixed latency it returns the rotated sample and a matching valid flag.

Only the first eighth of a cosine/sine period is tabulated. The index is split into a three-bit octant and an offset inside the octant. In odd octants the offset is mirrored. The cosine and sine values read from the table are then swapped and negated to rebuild the twiddle for any angle.

Three kinds of index avoid the table and the multipliers entirely:
- Multiples of N/4 become a pass-through, a swap of the real and imaginary parts, or a negation.
- Odd multiples of N/8 use sums and differences of the two parts, scaled by a shift-and-add constant.
- All other indices use a complex product built from three real multiplies and five additions.

Top module: `twiddle_rotator`

## Requirements
- R1: While rst_n is low, out_valid, out_re and out_im are all 0.
- R2: Latency is 3 clock cycles on every path. out_valid equals in_valid from three cycles earlier, and a new input is accepted every cycle.
- R3: For k not a multiple of N/8, twiddle parts are wr = round(2^(TW-2)·cos(2πk/N)) and wi = round(−2^(TW-2)·sin(2πk/N)). The outputs are out_re = (wr·a − wi·b)/2^(TW-2) and out_im = (wr·b + wi·a)/2^(TW-2), where a = in_re and b = in_im.
- R4: For k = 0 the sample passes through unchanged, including the most negative value.
- R5: For k = N/4, out = (b, −a). For k = N/2, out = (−a, −b). For k = 3N/4, out = (−b, a).
- R6: For k = N/8, 3N/8, 5N/8 and 7N/8, the outputs are the signed sums s_re = wr·a − wi·b and s_im = wr·b + wi·a, where wr and wi are the signs (+1 or −1) of cos and −sin at that angle. Each sum is scaled by 181/256 in place of 1/√2.
- R7: Results outside the DW-bit signed range saturate to −2^(DW-1) or 2^(DW-1)−1. This includes negation of the most negative input.
- R8: Fractional results are rounded to the nearest integer, with ties going toward +∞.
- R9: in_k is an unsigned LOG2N-bit index, and every value from 0 to N−1 is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is valid |
| in_re | input | DW | Real part of the input, signed |
| in_im | input | DW | Imaginary part of the input, signed |
| in_k | input | LOG2N | Twiddle index k |
| out_valid | output | 1 | Output sample is valid |
| out_re | output | DW | Real part of the rotated sample, signed |
| out_im | output | DW | Imaginary part of the rotated sample, signed |

## Verification
Every index from 0 to N−1 is swept under several fixed data pairs:
- A unit vector on the real axis exposes the reconstructed twiddle directly, so a wrong octant swap or sign shows up as a wrong cosine or sine.
- The imaginary-axis counterpart does the same for the other part.
- Pairs at the full-scale corners drive the saturation and most-negative-negation cases on the trivial and diagonal paths.
- Small odd values expose rounding ties and the 181/256 constant.

A scrambled burst with mixed indices and idle gaps shows whether the valid flag and data stay aligned across path changes.

// File: rtl/twr_pkg.sv
`timescale 1ns/1ps
package twr_pkg;
   // Selects how a sample is rotated in the final stage.
   typedef enum logic [1:0] {
      PATH_GEN  = 2'd0,   // table twiddle, three-multiply product
      PATH_TRIV = 2'd1,   // multiple of a quarter turn
      PATH_DIAG = 2'd2    // odd multiple of an eighth turn
   } path_e;
endpackage

// File: rtl/twr_octant_rom.sv
`timescale 1ns/1ps
module twr_octant_rom
   import twr_pkg::*;
#(
   parameter int LOG2N = 7,
   parameter int TW    = 9
) (
   input  logic [LOG2N-1:0]     k,
   output logic signed [TW-1:0] wr,
   output logic signed [TW-1:0] wi,
   output path_e                path,
   output logic [2:0]           oct
);
   localparam int  RW    = LOG2N - 3;
   localparam int  N8    = 1 << RW;
   localparam int  NPTS  = 1 << LOG2N;
   localparam real PI    = 3.14159265358979323846;
   localparam real SCALE = real'(1 << (TW - 2));

   logic signed [TW-1:0] cos_t [N8];
   logic signed [TW-1:0] sin_t [N8];

   // First eighth of a period, quantised at elaboration.
   for (genvar g = 0; g < N8; g++) begin : g_rom
      localparam real ANG = 2.0 * PI * real'(g) / real'(NPTS);
      localparam int  CQ  = int'($floor(SCALE * $cos(ANG) + 0.5));
      localparam int  SQ  = int'($floor(SCALE * $sin(ANG) + 0.5));
      assign cos_t[g] = TW'(CQ);
      assign sin_t[g] = TW'(SQ);
   end

   logic [RW-1:0]        r;
   logic [RW-1:0]        idx;
   logic signed [TW-1:0] c;
   logic signed [TW-1:0] s;

   assign oct = k[LOG2N-1 -: 3];
   assign r   = k[RW-1:0];
   // Odd octants read the table from the far end.
   assign idx = oct[0] ? (RW'(0) - r) : r;
   assign c   = cos_t[idx];
   assign s   = sin_t[idx];

   always_comb begin
      case (oct)
         3'd0:    begin wr =  c; wi = -s; end
         3'd1:    begin wr =  s; wi = -c; end
         3'd2:    begin wr = -s; wi = -c; end
         3'd3:    begin wr = -c; wi = -s; end
         3'd4:    begin wr = -c; wi =  s; end
         3'd5:    begin wr = -s; wi =  c; end
         3'd6:    begin wr =  s; wi =  c; end
         default: begin wr =  c; wi =  s; end
      endcase
   end

   assign path = (r != '0) ? PATH_GEN : (oct[0] ? PATH_DIAG : PATH_TRIV);
endmodule

// File: rtl/twr_cmul3.sv
`timescale 1ns/1ps
module twr_cmul3 #(
   parameter int DW = 9,
   parameter int TW = 9
) (
   input  logic signed [DW-1:0] a,
   input  logic signed [DW-1:0] b,
   input  logic signed [TW-1:0] wr,
   input  logic signed [TW-1:0] wi,
   output logic signed [DW+TW:0] k1,
   output logic signed [DW+TW:0] k2,
   output logic signed [DW+TW:0] k3
);
   localparam int PW = DW + TW + 1;

   logic signed [DW:0] sab;
   logic signed [TW:0] dwd;
   logic signed [TW:0] swd;

   // Three of the five additions sit ahead of the multipliers.
   assign sab = (DW+1)'(a) + (DW+1)'(b);
   assign dwd = (TW+1)'(wi) - (TW+1)'(wr);
   assign swd = (TW+1)'(wr) + (TW+1)'(wi);

   assign k1 = PW'(sab) * PW'(wr);
   assign k2 = PW'(a)   * PW'(dwd);
   assign k3 = PW'(b)   * PW'(swd);
endmodule

// File: rtl/twr_diag.sv
`timescale 1ns/1ps
module twr_diag #(
   parameter int DW = 9
) (
   input  logic signed [DW-1:0] a,
   input  logic signed [DW-1:0] b,
   input  logic [1:0]           sel,   // octant 1, 3, 5, 7
   output logic signed [DW+9:0] dre,
   output logic signed [DW+9:0] dim
);
   logic signed [DW+1:0] sp;
   logic signed [DW+1:0] sm;
   logic signed [DW+1:0] xr;
   logic signed [DW+1:0] xi;

   assign sp = (DW+2)'(a) + (DW+2)'(b);
   assign sm = (DW+2)'(a) - (DW+2)'(b);

   always_comb begin
      case (sel)
         2'd0:    begin xr =  sp; xi = -sm; end
         2'd1:    begin xr = -sm; xi = -sp; end
         2'd2:    begin xr = -sp; xi =  sm; end
         default: begin xr =  sm; xi =  sp; end
      endcase
   end

   // 181/256 stands in for 1/sqrt(2): 128 + 32 + 16 + 4 + 1.
   function automatic logic signed [DW+9:0] by181(input logic signed [DW+1:0] x);
      logic signed [DW+9:0] e;
      e = (DW+10)'(x);
      return (e <<< 7) + (e <<< 5) + (e <<< 4) + (e <<< 2) + e;
   endfunction

   assign dre = by181(xr);
   assign dim = by181(xi);
endmodule

// File: rtl/twr_round_sat.sv
`timescale 1ns/1ps
module twr_round_sat #(
   parameter int IW = 24,
   parameter int F  = 8,
   parameter int DW = 9
) (
   input  logic signed [IW-1:0] x,
   output logic signed [DW-1:0] y
);
   localparam logic signed [IW-1:0] HALF = IW'(1) <<< (F - 1);
   localparam logic signed [IW-1:0] MAXV = IW'((1 << (DW - 1)) - 1);
   localparam logic signed [IW-1:0] MINV = IW'(-(1 << (DW - 1)));

   logic signed [IW-1:0] t;

   assign t = (x + HALF) >>> F;
   assign y = (t > MAXV) ? DW'(MAXV) : ((t < MINV) ? DW'(MINV) : DW'(t));
endmodule

// File: rtl/twiddle_rotator.sv
`timescale 1ns/1ps
module twiddle_rotator
   import twr_pkg::*;
#(
   parameter int DW    = 9,
   parameter int TW    = 9,
   parameter int LOG2N = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   input  logic [LOG2N-1:0]     in_k,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_re,
   output logic signed [DW-1:0] out_im
);
   localparam int PW  = DW + TW + 1;
   localparam int DIW = DW + 10;
   localparam int FG  = TW - 2;
   localparam int FD  = 8;
   localparam int F   = (FG > FD) ? FG : FD;
   localparam int GW  = PW + 1 + F - FG;
   localparam int AW  = DIW + F - FD;
   localparam int WW  = ((GW > AW) ? GW : AW) + 1;

   if (LOG2N < 4 || LOG2N > 11) begin : g_bad_log2n
      $error("twiddle_rotator: LOG2N must lie in 4..11");
   end
   if (TW < 4 || TW > 18) begin : g_bad_tw
      $error("twiddle_rotator: TW must lie in 4..18");
   end
   if (DW < 4 || DW > 24) begin : g_bad_dw
      $error("twiddle_rotator: DW must lie in 4..24");
   end

   // ---------------- stage 1: decode index, read table ----------------
   logic signed [TW-1:0] t_wr, t_wi;
   path_e                t_path;
   logic [2:0]           t_oct;

   twr_octant_rom #(.LOG2N(LOG2N), .TW(TW)) u_rom (
      .k(in_k), .wr(t_wr), .wi(t_wi), .path(t_path), .oct(t_oct)
   );

   logic                 s1_v;
   logic signed [DW-1:0] s1_a, s1_b;
   logic signed [TW-1:0] s1_wr, s1_wi;
   path_e                s1_path;
   logic [2:0]           s1_oct;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_a    <= '0;
         s1_b    <= '0;
         s1_wr   <= '0;
         s1_wi   <= '0;
         s1_path <= PATH_GEN;
         s1_oct  <= '0;
      end else begin
         s1_v    <= in_valid;
         s1_a    <= in_re;
         s1_b    <= in_im;
         s1_wr   <= t_wr;
         s1_wi   <= t_wi;
         s1_path <= t_path;
         s1_oct  <= t_oct;
      end
   end

   // ---------------- stage 2: multiply or shortcut ----------------
   logic signed [PW-1:0]  m_k1, m_k2, m_k3;
   logic signed [DIW-1:0] d_re, d_im;
   logic signed [DW:0]    tr, ti;
   logic signed [DIW-1:0] alt_re, alt_im;

   twr_cmul3 #(.DW(DW), .TW(TW)) u_mul (
      .a(s1_a), .b(s1_b), .wr(s1_wr), .wi(s1_wi),
      .k1(m_k1), .k2(m_k2), .k3(m_k3)
   );

   twr_diag #(.DW(DW)) u_diag (
      .a(s1_a), .b(s1_b), .sel(s1_oct[2:1]), .dre(d_re), .dim(d_im)
   );

   always_comb begin
      case (s1_oct[2:1])
         2'd0:    begin tr =  (DW+1)'(s1_a); ti =  (DW+1)'(s1_b); end
         2'd1:    begin tr =  (DW+1)'(s1_b); ti = -(DW+1)'(s1_a); end
         2'd2:    begin tr = -(DW+1)'(s1_a); ti = -(DW+1)'(s1_b); end
         default: begin tr = -(DW+1)'(s1_b); ti =  (DW+1)'(s1_a); end
      endcase
   end

   assign alt_re = (s1_path == PATH_DIAG) ? d_re : (DIW'(tr) <<< FD);
   assign alt_im = (s1_path == PATH_DIAG) ? d_im : (DIW'(ti) <<< FD);

   logic                  s2_v;
   logic signed [PW-1:0]  s2_k1, s2_k2, s2_k3;
   logic signed [DIW-1:0] s2_alt_re, s2_alt_im;
   path_e                 s2_path;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_v      <= 1'b0;
         s2_k1     <= '0;
         s2_k2     <= '0;
         s2_k3     <= '0;
         s2_alt_re <= '0;
         s2_alt_im <= '0;
         s2_path   <= PATH_GEN;
      end else begin
         s2_v      <= s1_v;
         s2_k1     <= m_k1;
         s2_k2     <= m_k2;
         s2_k3     <= m_k3;
         s2_alt_re <= alt_re;
         s2_alt_im <= alt_im;
         s2_path   <= s1_path;
      end
   end

   // ---------------- stage 3: combine, round, saturate ----------------
   logic signed [PW:0]    g_re, g_im;
   logic signed [WW-1:0]  acc [2];
   logic signed [DW-1:0]  rs  [2];

   // Last two of the five additions.
   assign g_re = (PW+1)'(s2_k1) - (PW+1)'(s2_k3);
   assign g_im = (PW+1)'(s2_k1) + (PW+1)'(s2_k2);

   assign acc[0] = (s2_path == PATH_GEN) ? (WW'(g_re) <<< (F - FG))
                                         : (WW'(s2_alt_re) <<< (F - FD));
   assign acc[1] = (s2_path == PATH_GEN) ? (WW'(g_im) <<< (F - FG))
                                         : (WW'(s2_alt_im) <<< (F - FD));

   for (genvar c = 0; c < 2; c++) begin : g_rsat
      twr_round_sat #(.IW(WW), .F(F), .DW(DW)) u_rs (.x(acc[c]), .y(rs[c]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
      end else begin
         out_valid <= s2_v;
         out_re    <= rs[0];
         out_im    <= rs[1];
      end
   end
endmodule

// File: rtl/twiddle_rotator_chk.sv
`timescale 1ns/1ps
module twiddle_rotator_chk #(
   parameter int DW    = 9,
   parameter int TW    = 9,
   parameter int LOG2N = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic signed [DW-1:0] in_re,
   input logic signed [DW-1:0] in_im,
   input logic [LOG2N-1:0]     in_k,
   input logic                 out_valid,
   input logic signed [DW-1:0] out_re,
   input logic signed [DW-1:0] out_im
);
   localparam int NPTS = 1 << LOG2N;
   localparam logic signed [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};
   localparam logic signed [DW-1:0] DMAX = ~DMIN;

   // Edges seen since reset left; the pipeline is fully defined at 3.
   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            warm <= '0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] v);
      return (v == DMIN) ? DMAX : -v;
   endfunction

   p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   p_pass_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3 && $past(in_valid && in_k == '0, 3)) |->
      (out_re == $past(in_re, 3) && out_im == $past(in_im, 3)));

   p_quarter_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3 && $past(in_valid && in_k == LOG2N'(NPTS / 4), 3)) |->
      (out_re == $past(in_im, 3) && out_im == neg_sat($past(in_re, 3))));

   p_half_negate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3 && $past(in_valid && in_k == LOG2N'(NPTS / 2), 3)) |->
      (out_re == neg_sat($past(in_re, 3)) && out_im == neg_sat($past(in_im, 3))));
endmodule

bind twiddle_rotator twiddle_rotator_chk #(.DW(DW), .TW(TW), .LOG2N(LOG2N)) i_chk (.*);

// File: tb/test_twiddle_rotator.sv
`timescale 1ns/1ps
module test_twiddle_rotator;
   localparam int  DW    = 9;
   localparam int  TW    = 9;
   localparam int  LOG2N = 7;
   localparam int  NPTS  = 1 << LOG2N;
   localparam real PI    = 3.14159265358979323846;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic signed [DW-1:0] in_re = '0;
   logic signed [DW-1:0] in_im = '0;
   logic [LOG2N-1:0]     in_k = '0;
   logic                 out_valid;
   logic signed [DW-1:0] out_re;
   logic signed [DW-1:0] out_im;

   twiddle_rotator #(.DW(DW), .TW(TW), .LOG2N(LOG2N)) i_twiddle_rotator (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re),
      .in_im(in_im), .in_k(in_k), .out_valid(out_valid),
      .out_re(out_re), .out_im(out_im)
   );

   always #5 clk = ~clk;

   int    checks = 0;
   int    fails  = 0;
   int    it     = 0;
   bit    hv   [4096];
   int    her  [4096];
   int    hei  [4096];
   string htag [4096];

   function automatic int rnd(real x);
      return int'($floor(x + 0.5));
   endfunction

   function automatic int sat(int v, inout bit hit);
      if (v > 255)  begin hit = 1'b1; return 255;  end
      if (v < -256) begin hit = 1'b1; return -256; end
      return v;
   endfunction

   // Expected result straight from the requirements.
   task automatic model(input int a, input int b, input int k,
                        output int er, output int ei, output string tag);
      real th;
      int  wr, wi, nr, ni;
      bit  hit;
      hit = 1'b0;
      th  = 2.0 * PI * real'(k) / real'(NPTS);
      if (k % (NPTS / 4) == 0) begin
         case (k / (NPTS / 4))
            0:       begin wr =  1; wi =  0; end
            1:       begin wr =  0; wi = -1; end
            2:       begin wr = -1; wi =  0; end
            default: begin wr =  0; wi =  1; end
         endcase
         nr  = wr * a - wi * b;
         ni  = wr * b + wi * a;
         tag = (k == 0) ? "R4" : "R5";
      end else if (k % (NPTS / 8) == 0) begin
         wr  = ($cos(th) > 0.0) ? 1 : -1;
         wi  = (-$sin(th) > 0.0) ? 1 : -1;
         nr  = ((wr * a - wi * b) * 181 + 128) >>> 8;
         ni  = ((wr * b + wi * a) * 181 + 128) >>> 8;
         tag = "R6 R8";
      end else begin
         wr  = rnd(128.0 * $cos(th));
         wi  = rnd(-128.0 * $sin(th));
         nr  = (wr * a - wi * b + 64) >>> 7;
         ni  = (wr * b + wi * a + 64) >>> 7;
         tag = "R3 R8 R9";
      end
      er = sat(nr, hit);
      ei = sat(ni, hit);
      if (hit) tag = {tag, " R7"};
   endtask

   task automatic check_out(input int idx);
      checks++;
      if (out_valid !== hv[idx]) begin
         fails++;
         $display("FAIL R2 valid step %0d: got %b expected %b", idx, out_valid, hv[idx]);
      end
      if (hv[idx]) begin
         checks++;
         if (int'(out_re) != her[idx] || int'(out_im) != hei[idx]) begin
            fails++;
            $display("FAIL %s step %0d: got (%0d,%0d) expected (%0d,%0d)",
                     htag[idx], idx, out_re, out_im, her[idx], hei[idx]);
         end
      end
   endtask

   task automatic step(input bit v, input int a, input int b, input int k);
      @(negedge clk);
      if (it >= 3) check_out(it - 3);
      in_valid = v;
      in_re    = DW'(a);
      in_im    = DW'(b);
      in_k     = LOG2N'(k);
      hv[it]   = v;
      if (v) model(a, b, k, her[it], hei[it], htag[it]);
      it++;
   endtask

   int pa [10] = '{100, 0, -256, 255, 255, -256, 37, 1, -1, 255};
   int pb [10] = '{0, 100, -256, 255, -256, 255, -91, 1, 0, 0};

   initial begin
      #2000000;
      fails++;
      checks++;
      $display("FAIL R2 watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      // R1: outputs held at zero while reset is low, even with activity.
      in_valid = 1'b1;
      in_re    = 9'sd77;
      in_k     = 7'd5;
      repeat (4) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_re !== '0 || out_im !== '0) begin
         fails++;
         $display("FAIL R1 reset: got v=%b (%0d,%0d) expected v=0 (0,0)",
                  out_valid, out_re, out_im);
      end
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // Full index sweep (R3, R4, R5, R6, R9) under each data pair.
      for (int p = 0; p < 10; p++) begin
         for (int k = 0; k < NPTS; k++) step(1'b1, pa[p], pb[p], k);
         step(1'b0, 0, 0, 0);
         step(1'b0, 0, 0, 0);
      end

      // Scrambled burst with gaps: R2 alignment across path changes.
      for (int i = 0; i < 300; i++) begin
         step((i % 7) != 3, ((i * 73) % 512) - 256, ((i * 151 + 29) % 512) - 256,
              (i * 11) % NPTS);
      end

      // Drain the pipeline.
      for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule